// File: doc/BRIEF.md
# DRAM Output Driver Control

This block sits on the data side of a DRAM core. It decides, from the row strobe, column strobe, write enable and output enable, whether the data pins are driven and what value they carry. All four strobes are active-low and are sampled on a fast system clock, so each one is treated as a synchronous input. Edge detection works by comparing each sample with the sample one cycle earlier.

Each row cycle is classified as one of the following: read, early write, late write, read-modify-write, row-only refresh, column-before-row refresh, or column-only. The block then applies the I/O rule for that class. Read data from the array is captured into an output latch whenever the column path is open for reading. The pins present that latch, gated by a drive enable.

The drive enable persists through a hidden refresh, where the row strobe rises while the column strobe stays low and then falls again. Output enable only masks the pins and never alters the latch. The block also flags when a column access is permitted, and it suppresses that flag during column-before-row refresh.

Top module: `dram_out_ctrl`

## Requirements
- R1: After reset `dq_oe_o` is 0, `dq_o` is 0, `col_acc_o` is 0 and `cyc_cls_o` is 0 (idle).
- R2: `cyc_cls_o` uses this encoding: 0 idle, 1 read, 2 early write, 3 late write, 4 read-modify-write, 5 row-only, 6 column-before-row refresh, 7 column-only. A row strobe falling edge sampled with the column strobe high gives 5. If the column strobe is sampled low at that edge, the result is 6, and 6 holds until the row strobe rises.
- R3: A column strobe falling edge sampled while the row strobe is low, and outside class 6, gives class 1 if write enable is high and class 2 if write enable is low. An early write never drives the pins.
- R4: A write enable falling edge in class 1, with the column strobe low, gives class 4 if output enable was sampled low since the column strobe fell. Otherwise it gives class 3.
- R5: With the row and column strobes low, write enable high, output enable low and class 1, 3 or 4, `dq_oe_o` is 1 on the next cycle and `dq_o` equals that cycle's `rd_data_i`.
- R6: The column strobe sampled high gives `dq_oe_o` = 0 on the next cycle. A column strobe falling edge sampled while the row strobe is high gives class 7 and does not turn the drivers on.
- R7: Output enable sampled high gives `dq_oe_o` = 0 on the next cycle and does not stop `dq_o` from following the latch.
- R8: Write enable sampled low while the column strobe is low gives `dq_oe_o` = 0 on the next cycle.
- R9: A row strobe rise while the column strobe stays low keeps the drive state and the latched data. In class 6, the drive state and `dq_o` keep their previous values.
- R10: `col_acc_o` is 1 on the cycle after a sample with both row and column strobes low, except in class 6.
- R11: The latch loads only when both strobes are low, write enable is high, and the class is 1, 3 or 4. In every other cycle `dq_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| rd_data_i | input | DW | Read data from the array |
| dq_o | output | DW | Output latch contents |
| dq_oe_o | output | 1 | Pin drive enable |
| cyc_cls_o | output | 3 | Current cycle class |
| col_acc_o | output | 1 | Column access permitted |

## Verification
Every output is registered, so each output reflects the strobes sampled at the previous edge. Edge-dependent results, such as a class change on a falling strobe, appear on the cycle after the edge is sampled. The bench drives inputs on the falling clock edge and compares every output against its behavioural model on the next falling edge, which is one full register stage later. Directed checks follow the same one-cycle rule after each step of a scripted strobe sequence covering page reads, late and early writes, read-modify-write, column-only, column-before-row refresh and hidden refresh.

// File: rtl/dram_oc_pkg.sv
package dram_oc_pkg;
  typedef enum logic [2:0] {
    CLS_IDLE     = 3'd0,
    CLS_READ     = 3'd1,
    CLS_EARLY_WR = 3'd2,
    CLS_LATE_WR  = 3'd3,
    CLS_RMW      = 3'd4,
    CLS_RAS_ONLY = 3'd5,
    CLS_CBR      = 3'd6,
    CLS_CAS_ONLY = 3'd7
  } cyc_cls_e;
endpackage

// File: rtl/dram_oc_edge.sv
module dram_oc_edge #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] strb_n_i,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b1;
      else         prev_q[g] <= strb_n_i[g];
    end
    assign fall_o[g] = prev_q[g] & ~strb_n_i[g];
  end
endmodule

// File: rtl/dram_oc_class.sv
module dram_oc_class
  import dram_oc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ras_n_i,
  input  logic     cas_n_i,
  input  logic     we_n_i,
  input  logic     oe_n_i,
  input  logic     ras_fall_i,
  input  logic     cas_fall_i,
  input  logic     we_fall_i,
  output cyc_cls_e cls_nx_o,
  output cyc_cls_e cls_o
);
  cyc_cls_e cls_q;
  logic     oe_seen_q, oe_seen_nx;

  always_comb begin
    cls_nx_o = cls_q;
    if (ras_n_i) begin
      cls_nx_o = cas_n_i ? CLS_IDLE : CLS_CAS_ONLY;
    end else if (ras_fall_i) begin
      cls_nx_o = cas_n_i ? CLS_RAS_ONLY : CLS_CBR;
    end else if (cls_q == CLS_CBR) begin
      cls_nx_o = CLS_CBR;
    end else if (cas_fall_i) begin
      cls_nx_o = we_n_i ? CLS_READ : CLS_EARLY_WR;
    end else if (cls_q == CLS_READ && !cas_n_i && we_fall_i) begin
      cls_nx_o = oe_seen_q ? CLS_RMW : CLS_LATE_WR;
    end
  end

  // read phase observed with output enabled since CAS fell
  always_comb begin
    if (cas_n_i)         oe_seen_nx = 1'b0;
    else if (cas_fall_i) oe_seen_nx = ~oe_n_i;
    else                 oe_seen_nx = oe_seen_q | ~oe_n_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_q     <= CLS_IDLE;
      oe_seen_q <= 1'b0;
    end else begin
      cls_q     <= cls_nx_o;
      oe_seen_q <= oe_seen_nx;
    end
  end

  assign cls_o = cls_q;

  p_ras_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_fall_i && cas_n_i) |=> (cls_q == CLS_RAS_ONLY));
  p_cbr_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_fall_i && !cas_n_i) |=> (cls_q == CLS_CBR));
  p_early_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_i && !ras_fall_i && cas_fall_i && !we_n_i && cls_q != CLS_CBR)
    |=> (cls_q == CLS_EARLY_WR));
  p_cas_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_n_i && cas_fall_i) |=> (cls_q == CLS_CAS_ONLY));
endmodule

// File: rtl/dram_oc_out.sv
module dram_oc_out
  import dram_oc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ras_n_i,
  input  logic          cas_n_i,
  input  logic          we_n_i,
  input  logic          oe_n_i,
  input  cyc_cls_e      cls_nx_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic          col_acc_o
);
  logic [DW-1:0] data_q;
  logic          en_q, en_nx, oe_q, col_q, rd_cls, load;

  assign rd_cls = (cls_nx_i == CLS_READ) || (cls_nx_i == CLS_RMW) ||
                  (cls_nx_i == CLS_LATE_WR);
  assign load   = !ras_n_i && !cas_n_i && we_n_i && rd_cls;

  always_comb begin
    if (cas_n_i)                  en_nx = 1'b0;
    else if (ras_n_i)             en_nx = en_q;   // hidden refresh / CAS-only
    else if (cls_nx_i == CLS_CBR) en_nx = en_q;
    else if (rd_cls)              en_nx = we_n_i;
    else                          en_nx = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      en_q   <= 1'b0;
      oe_q   <= 1'b0;
      col_q  <= 1'b0;
    end else begin
      if (load) data_q <= rd_data_i;
      en_q  <= en_nx;
      oe_q  <= ~oe_n_i;
      col_q <= !ras_n_i && !cas_n_i && (cls_nx_i != CLS_CBR);
    end
  end

  assign dq_o      = data_q;
  assign dq_oe_o   = en_q & oe_q;
  assign col_acc_o = col_q;

  p_cas_high_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_n_i |=> !dq_oe_o);
  p_oe_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_n_i |=> !dq_oe_o);
  p_we_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_n_i && !we_n_i && !ras_n_i && cls_nx_i != CLS_CBR) |=> !dq_oe_o);
  p_cbr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_nx_i == CLS_CBR) |=> $stable(dq_o));
  p_cbr_no_col_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_nx_i == CLS_CBR) |=> !col_acc_o);
  p_ras_high_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_n_i |=> $stable(dq_o));
endmodule

// File: rtl/dram_out_ctrl.sv
module dram_out_ctrl
  import dram_oc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ras_ni,
  input  logic          cas_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [DW-1:0] rd_data_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic [2:0]    cyc_cls_o,
  output logic          col_acc_o
);
  localparam int NSTRB = 3;

  logic [NSTRB-1:0] fall;
  cyc_cls_e         cls_nx, cls;

  dram_oc_edge #(.N(NSTRB)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strb_n_i ({we_ni, cas_ni, ras_ni}),
    .fall_o   (fall)
  );

  dram_oc_class u_class (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ras_n_i    (ras_ni),
    .cas_n_i    (cas_ni),
    .we_n_i     (we_ni),
    .oe_n_i     (oe_ni),
    .ras_fall_i (fall[0]),
    .cas_fall_i (fall[1]),
    .we_fall_i  (fall[2]),
    .cls_nx_o   (cls_nx),
    .cls_o      (cls)
  );

  dram_oc_out #(.DW(DW)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ras_n_i   (ras_ni),
    .cas_n_i   (cas_ni),
    .we_n_i    (we_ni),
    .oe_n_i    (oe_ni),
    .cls_nx_i  (cls_nx),
    .rd_data_i (rd_data_i),
    .dq_o      (dq_o),
    .dq_oe_o   (dq_oe_o),
    .col_acc_o (col_acc_o)
  );

  assign cyc_cls_o = cls;
endmodule

// File: tb/dram_out_ctrl_tb.sv
module dram_out_ctrl_tb_top;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [DW-1:0] rd_data = '0;
  logic [DW-1:0] dq;
  logic          dq_oe, col_acc;
  logic [2:0]    cls;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dram_out_ctrl #(.DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .oe_ni(oe_n), .rd_data_i(rd_data),
    .dq_o(dq), .dq_oe_o(dq_oe), .cyc_cls_o(cls), .col_acc_o(col_acc)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference
  int m_cls = 0, m_en = 0, m_oe = 0, m_col = 0, m_dat = 0, m_seen = 0;
  int p_ras = 1, p_cas = 1, p_we = 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cls = 0; m_en = 0; m_oe = 0; m_col = 0; m_dat = 0; m_seen = 0;
      p_ras = 1; p_cas = 1; p_we = 1;
    end else begin
      int r, c, w, o, nc, ne;
      bit rd;
      r = ras_n; c = cas_n; w = we_n; o = oe_n;
      nc = m_cls;
      if (r == 1)                      nc = (c == 1) ? 0 : 7;
      else if (p_ras == 1)             nc = (c == 1) ? 5 : 6;
      else if (m_cls == 6)             nc = 6;
      else if (p_cas == 1 && c == 0)   nc = (w == 1) ? 1 : 2;
      else if (m_cls == 1 && c == 0 && p_we == 1 && w == 0) nc = m_seen ? 4 : 3;
      rd = (nc == 1 || nc == 3 || nc == 4);
      if (c == 1)       ne = 0;
      else if (r == 1)  ne = m_en;
      else if (nc == 6) ne = m_en;
      else if (rd)      ne = w;
      else              ne = 0;
      if (r == 0 && c == 0 && w == 1 && rd) m_dat = rd_data;
      m_col = (r == 0 && c == 0 && nc != 6);
      if (c == 1)           m_seen = 0;
      else if (p_cas == 1)  m_seen = (o == 0);
      else                  m_seen = m_seen | (o == 0);
      m_cls = nc; m_en = ne; m_oe = (o == 0);
      p_ras = r; p_cas = c; p_we = w;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5",  "model dq_oe", dq_oe, m_en & m_oe);
      chk("R11", "model dq",    dq, m_dat);
      chk("R2",  "model class", cls, m_cls);
      chk("R10", "model col",   col_acc, m_col);
    end
  end

  task automatic step(input logic r, input logic c, input logic w, input logic o,
                      input logic [DW-1:0] d);
    ras_n = r; cas_n = c; we_n = w; oe_n = o; rd_data = d;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", "reset dq_oe", dq_oe, 0);
    chk("R1", "reset dq", dq, 0);
    chk("R1", "reset class", cls, 0);
    chk("R1", "reset col", col_acc, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // page read
    step(0, 1, 1, 0, 16'h1111);
    chk("R2", "row-only class", cls, 5);
    step(0, 0, 1, 0, 16'hA5A5);
    chk("R3", "read class", cls, 1);
    chk("R5", "read drive", dq_oe, 1);
    chk("R5", "read data", dq, 16'hA5A5);
    chk("R10", "col access", col_acc, 1);
    step(0, 0, 1, 1, 16'hB0B0);
    chk("R7", "oe mask", dq_oe, 0);
    chk("R7", "latch under oe high", dq, 16'hB0B0);
    step(0, 1, 1, 0, 16'hC0C0);
    chk("R6", "cas high off", dq_oe, 0);
    chk("R11", "no load cas high", dq, 16'hB0B0);
    // late write
    step(0, 0, 1, 1, 16'hD0D0);
    step(0, 0, 0, 1, 16'hD0D0);
    chk("R4", "late write class", cls, 3);
    chk("R8", "late write off", dq_oe, 0);
    // read-modify-write
    step(0, 1, 1, 0, 16'h0);
    step(0, 0, 1, 0, 16'hE0E0);
    chk("R5", "rmw read drive", dq_oe, 1);
    step(0, 0, 0, 0, 16'hF0F0);
    chk("R4", "rmw class", cls, 4);
    chk("R8", "we low off", dq_oe, 0);
    chk("R11", "no load we low", dq, 16'hE0E0);
    // early write
    step(0, 1, 1, 1, 16'h0);
    step(0, 0, 0, 0, 16'h1234);
    chk("R3", "early write class", cls, 2);
    chk("R3", "early write hi-z", dq_oe, 0);
    chk("R11", "no load early write", dq, 16'hE0E0);
    // column-only, then CBR
    step(1, 1, 1, 1, 16'h0);
    chk("R2", "idle class", cls, 0);
    step(1, 0, 1, 0, 16'h5555);
    chk("R6", "cas-only class", cls, 7);
    chk("R6", "cas-only hi-z", dq_oe, 0);
    step(0, 0, 1, 0, 16'h6666);
    chk("R2", "cbr class", cls, 6);
    chk("R9", "cbr keeps hi-z", dq_oe, 0);
    chk("R10", "cbr no col", col_acc, 0);
    chk("R9", "cbr keeps data", dq, 16'hE0E0);
    // hidden refresh
    step(1, 1, 1, 1, 16'h0);
    step(0, 1, 1, 0, 16'h0);
    step(0, 0, 1, 0, 16'h7777);
    chk("R5", "hidden read drive", dq_oe, 1);
    step(1, 0, 1, 0, 16'h8888);
    chk("R9", "ras rise keeps drive", dq_oe, 1);
    chk("R9", "ras rise keeps data", dq, 16'h7777);
    step(0, 0, 1, 0, 16'h9999);
    chk("R2", "hidden cbr class", cls, 6);
    chk("R9", "cbr keeps drive", dq_oe, 1);
    chk("R9", "cbr data", dq, 16'h7777);
    step(0, 0, 1, 1, 16'h9999);
    chk("R7", "oe mask in cbr", dq_oe, 0);
    step(0, 0, 1, 0, 16'h9999);
    chk("R7", "oe low again restores", dq_oe, 1);
    chk("R7", "latch untouched by oe", dq, 16'h7777);
    step(1, 1, 1, 1, 16'h0);
    chk("R6", "end off", dq_oe, 0);
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule